// File: doc/BRIEF.md
# Configurable UART Transmitter with Carrier Modulation

This block serialises bytes onto a single output line in asynchronous serial frames. Three run-time controls set the frame shape: 7 or 8 data bits, an optional parity bit with even or odd sense, and 1 or 2 stop bits. The bit rate comes from a reload counter that produces base ticks. A sub-divider then counts 16 or 4 of those ticks per bit. Software loads bytes through a one-deep hold register. Two sticky flags report the transmitter state: one says the hold register is empty, the other says transmission has ended. Each flag has an interrupt mask, and each is cleared by writing 1 to it.

The serial line can optionally pass through a carrier stage before it leaves the block. This stage switches a square wave onto either the high or the low periods of the line. An optional inversion is applied after the carrier stage. Before the transmitter runs, it needs one software-reset pulse after power-on reset and a held-high module enable. While the enable is low, the engine stays in its reset state.

Top module: `uart_tx_carrier`

## Requirements
- R1: After reset the output `tx_out` is 1 (idle, no inversion), `buf_empty` is 1, `tx_end` is 0, and `irq` follows `(buf_empty & irq_en[0]) | (tx_end & irq_en[1])`. Setting `irq_en[0]` right after reset therefore raises `irq` at once.
- R2: Until a `sw_rst` pulse has been seen since reset, byte writes have no effect. The line stays idle and `buf_empty` stays 1.
- R3: A frame is sent in this order: a start bit of 0, then the data bits least-significant first, then the parity bit if enabled, then the stop bits of value 1. With nothing to send, the pre-inversion line is 1.
- R4: `len8`=1 sends 8 data bits. `len8`=0 sends only bits 0 to 6 of the byte.
- R5: When `par_en`=1, one parity bit follows the data. With `par_odd`=0, the number of ones across the sent data bits and the parity bit is even. With `par_odd`=1, that number is odd.
- R6: `stop2`=0 sends one stop bit and `stop2`=1 sends two. `tx_end` rises exactly when the last stop bit period ends and no byte is waiting.
- R7: Each bit lasts `(baud_reload+1) * (div4 ? 4 : 16)` clock cycles.
- R8: `buf_empty` sets when a byte moves from the hold register into the shifter. An accepted write clears it. Writing 1 to `flag_clr[0]` clears `buf_empty`, and writing 1 to `flag_clr[1]` clears `tx_end`.
- R9: If a byte is waiting when a frame's last stop bit ends, its start bit follows in the very next bit period. No idle bit is inserted and `tx_end` stays 0.
- R10: A write that arrives while the hold register still holds a byte that is not leaving in that cycle is dropped.
- R11: With `car_en`=1, a carrier of half-period `car_period+1` cycles replaces the line during its target level. The target is high when `car_low`=0 and low when `car_low`=1. The other level passes unchanged.
- R12: `inv_out`=1 inverts the output after the carrier stage.
- R13: Dropping `mod_en` returns the line to idle at once, empties the hold register (`buf_empty`=1, `tx_end`=0) and abandons any frame in progress. Raising `mod_en` again resumes operation without a new `sw_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Software reset pulse; also arms the transmitter |
| mod_en | input | 1 | Module enable |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop2 | input | 1 | 1: two stop bits |
| div4 | input | 1 | 1: 4 base ticks per bit, 0: 16 |
| baud_reload | input | RELOAD_W | Base tick period minus one, in clock cycles |
| car_en | input | 1 | Carrier stage enable |
| car_low | input | 1 | 1: carrier on low periods, 0: on high periods |
| car_period | input | CAR_W | Carrier half-period minus one, in clock cycles |
| inv_out | input | 1 | Output inversion |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| flag_clr | input | 2 | Write-1-to-clear: bit 0 buf_empty, bit 1 tx_end |
| irq_en | input | 2 | Interrupt masks: bit 0 buf_empty, bit 1 tx_end |
| tx_out | output | 1 | Serial output |
| buf_empty | output | 1 | Hold register empty flag |
| tx_end | output | 1 | Transmission end flag |
| irq | output | 1 | Masked OR of the flags |

## Verification
The bench builds the block with its default parameters: an 8-bit reload, an 8-bit carrier period and 16/4 sub-division. The reload value itself is driven at run time with small values from 0 to 3. This keeps bit periods between 4 and 64 cycles, so dozens of random frames fit in a short run. The timing check at the frame end is exact for every one of the eight frame shapes under both division ratios.

// File: rtl/uart_txc_pkg.sv
package uart_txc_pkg;

    localparam int DATA_MAX  = 8;
    localparam int FRAME_MAX = 1 + DATA_MAX + 1 + 2;
    localparam int LEFT_W    = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        logic len8;
        logic par_en;
        logic par_odd;
        logic stop2;
    } fmt_t;

    // Bit 0 leaves first; unused upper positions stay 1 (stop level).
    function automatic logic [FRAME_MAX-1:0] pack_frame(input fmt_t f, input logic [DATA_MAX-1:0] d);
        logic [FRAME_MAX-1:0] v;
        logic par;
        v    = '1;
        v[0] = 1'b0;
        par  = f.par_odd;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < DATA_MAX - 1 || f.len8) begin
                v[1+i] = d[i];
                par    = par ^ d[i];
            end
        end
        if (f.par_en) begin
            if (f.len8) v[DATA_MAX+1] = par;
            else        v[DATA_MAX]   = par;
        end
        return v;
    endfunction

    function automatic logic [LEFT_W-1:0] frame_bits(input fmt_t f);
        int n;
        n = DATA_MAX + 1 + int'(f.len8) + int'(f.par_en) + int'(f.stop2);
        return LEFT_W'(n);
    endfunction

endpackage

// File: rtl/txc_baud.sv
module txc_baud #(
    parameter int RELOAD_W  = 8,
    parameter int SUB_LONG  = 16,
    parameter int SUB_SHORT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                short_div,
    output logic                bit_tick
);
    localparam int SUB_W = $clog2(SUB_LONG);

    typedef struct packed {
        logic [RELOAD_W-1:0] cnt;
        logic [SUB_W-1:0]    sub;
    } baud_t;

    baud_t q, n;
    logic [SUB_W-1:0] sub_last;
    logic             base_tick;

    assign sub_last  = short_div ? SUB_W'(SUB_SHORT - 1) : SUB_W'(SUB_LONG - 1);
    assign base_tick = (q.cnt == '0);
    assign bit_tick  = run && base_tick && (q.sub == sub_last);

    always_comb begin
        n = q;
        if (!run) begin
            n.cnt = reload;
            n.sub = '0;
        end else if (base_tick) begin
            n.cnt = reload;
            n.sub = (q.sub == sub_last) ? '0 : q.sub + 1'b1;
        end else begin
            n.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    // R7: an idle generator restarts its bit count from zero
    p_idle_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (q.sub == '0));

endmodule

// File: rtl/txc_frame.sv
module txc_frame
    import uart_txc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  fmt_t                fmt,
    input  logic                wr_en,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                bit_tick,
    output logic                line,
    output logic                busy,
    output logic                loaded,
    output logic                finished,
    output logic                accepted
);
    typedef struct packed {
        logic                 busy;
        logic [FRAME_MAX-1:0] sh;
        logic [LEFT_W-1:0]    left;
        logic                 full;
        logic [DATA_MAX-1:0]  hold;
    } eng_t;

    localparam eng_t ENG_RST = '{busy: 1'b0, sh: '1, left: '0, full: 1'b0, hold: '0};

    eng_t q, n;
    logic last_bit, take;

    assign last_bit = q.busy && bit_tick && (q.left == LEFT_W'(1));
    assign take     = run && q.full && (!q.busy || last_bit);
    assign accepted = run && wr_en && (!q.full || take);
    assign loaded   = take;
    assign finished = run && last_bit && !q.full;

    always_comb begin
        n = q;
        if (!run) begin
            n = ENG_RST;
        end else begin
            if (q.busy && bit_tick) begin
                n.sh   = {1'b1, q.sh[FRAME_MAX-1:1]};
                n.left = q.left - 1'b1;
                if (last_bit) n.busy = 1'b0;
            end
            if (take) begin
                n.sh   = pack_frame(fmt, q.hold);
                n.left = frame_bits(fmt);
                n.busy = 1'b1;
                n.full = 1'b0;
            end
            if (accepted) begin
                n.hold = wr_data;
                n.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= n;
    end

    assign busy = q.busy;
    assign line = q.busy ? q.sh[0] : 1'b1;

    // R3: every frame opens with a low start bit
    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> (line == 1'b0));

    // R6: a running frame always has bits left to send
    p_left_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.left != '0));

    // R10: a waiting byte is not overwritten
    p_hold_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && !take) |=> $stable(q.hold));

endmodule

// File: rtl/txc_carrier.sv
module txc_carrier #(
    parameter int CAR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CAR_W-1:0] half_len,
    output logic             wave
);
    typedef struct packed {
        logic [CAR_W-1:0] cnt;
        logic             ph;
    } car_t;

    car_t q, n;

    always_comb begin
        n = q;
        if (!en) begin
            n = '0;
        end else if (q.cnt == half_len) begin
            n.cnt = '0;
            n.ph  = ~q.ph;
        end else begin
            n.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign wave = q.ph;

    // R11: a disabled carrier parks low
    p_park_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !q.ph);

endmodule

// File: rtl/uart_tx_carrier.sv
module uart_tx_carrier
    import uart_txc_pkg::*;
#(
    parameter int RELOAD_W  = 8,
    parameter int CAR_W     = 8,
    parameter int SUB_LONG  = 16,
    parameter int SUB_SHORT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_rst,
    input  logic                mod_en,
    input  logic                len8,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                stop2,
    input  logic                div4,
    input  logic [RELOAD_W-1:0] baud_reload,
    input  logic                car_en,
    input  logic                car_low,
    input  logic [CAR_W-1:0]    car_period,
    input  logic                inv_out,
    input  logic                wr_en,
    input  logic [7:0]          wr_data,
    input  logic [1:0]          flag_clr,
    input  logic [1:0]          irq_en,
    output logic                tx_out,
    output logic                buf_empty,
    output logic                tx_end,
    output logic                irq
);
    typedef struct packed {
        logic armed;
        logic bempty;
        logic tend;
    } ctl_t;

    localparam ctl_t CTL_RST = '{armed: 1'b0, bempty: 1'b1, tend: 1'b0};

    ctl_t q, n;
    fmt_t fmt;
    logic run, bit_tick, line, busy, loaded, finished, accepted, wave, shaped;

    assign run = q.armed && mod_en && !sw_rst;
    assign fmt = '{len8: len8, par_en: par_en, par_odd: par_odd, stop2: stop2};

    txc_baud #(
        .RELOAD_W (RELOAD_W),
        .SUB_LONG (SUB_LONG),
        .SUB_SHORT(SUB_SHORT)
    ) i_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run && busy),
        .reload   (baud_reload),
        .short_div(div4),
        .bit_tick (bit_tick)
    );

    txc_frame i_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .fmt     (fmt),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .bit_tick(bit_tick),
        .line    (line),
        .busy    (busy),
        .loaded  (loaded),
        .finished(finished),
        .accepted(accepted)
    );

    txc_carrier #(.CAR_W(CAR_W)) i_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (car_en),
        .half_len(car_period),
        .wave    (wave)
    );

    always_comb begin
        n = q;
        n.armed = q.armed | sw_rst;
        if (!run) begin
            n.bempty = 1'b1;
            n.tend   = 1'b0;
        end else begin
            if (flag_clr[0]) n.bempty = 1'b0;
            if (flag_clr[1]) n.tend   = 1'b0;
            if (loaded)      n.bempty = 1'b1;
            if (accepted)    n.bempty = 1'b0;
            if (finished)    n.tend   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= n;
    end

    // Carrier replaces the target level, then optional inversion.
    assign shaped    = (car_en && (line == !car_low)) ? wave : line;
    assign tx_out    = shaped ^ inv_out;
    assign buf_empty = q.bempty;
    assign tx_end    = q.tend;
    assign irq       = (q.bempty & irq_en[0]) | (q.tend & irq_en[1]);

    // R8: the end flag only rises once the shifter has stopped
    p_end_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.tend) |-> !busy);

    // R13: a stopped engine reports an empty hold register and no end event
    p_stopped_clean_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (q.bempty && !q.tend));

    // R2: writes before arming leave the hold register empty
    p_unarmed_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.armed && wr_en) |=> q.bempty);

endmodule

// File: tb/test_uart_tx_carrier.sv
module test_uart_tx_carrier;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_rst = 1'b0, mod_en = 1'b0;
    logic       len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, div4 = 1'b1;
    logic [7:0] baud_reload = 8'd0;
    logic       car_en = 1'b0, car_low = 1'b0;
    logic [7:0] car_period = 8'd0;
    logic       inv_out = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] flag_clr = 2'b00, irq_en = 2'b00;
    logic       tx_out, buf_empty, tx_end, irq;

    int  n_tests = 0, n_fail = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    uart_tx_carrier i_uart_tx_carrier (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .mod_en(mod_en),
        .len8(len8), .par_en(par_en), .par_odd(par_odd), .stop2(stop2), .div4(div4),
        .baud_reload(baud_reload), .car_en(car_en), .car_low(car_low),
        .car_period(car_period), .inv_out(inv_out), .wr_en(wr_en), .wr_data(wr_data),
        .flag_clr(flag_clr), .irq_en(irq_en), .tx_out(tx_out), .buf_empty(buf_empty),
        .tx_end(tx_end), .irq(irq)
    );

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int bit_time();
        return (int'(baud_reload) + 1) * (div4 ? 4 : 16);
    endfunction

    function automatic logic level();
        return tx_out ^ inv_out;
    endfunction

    // Expected frame: position 0 leaves first.
    function automatic logic [11:0] model_frame(input logic [7:0] d, output int nb);
        logic [11:0] f;
        int pos, nd, ones;
        f = '1;
        nd = len8 ? 8 : 7;
        pos = 0;
        f[pos] = 1'b0; pos++;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            f[pos] = d[i]; pos++;
            if (d[i]) ones++;
        end
        if (par_en) begin
            f[pos] = ((ones % 2) == 1) ^ par_odd; pos++;
        end
        pos += stop2 ? 2 : 1;
        nb = pos;
        return f;
    endfunction

    task automatic write_byte(input logic [7:0] d);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic find_start(input string req);
        int w;
        w = 0;
        while (level() != 1'b0 && w < 200) begin
            tick(1);
            w++;
        end
        chk(w < 200, req, w, 0);
        tick(bit_time() / 2);
    endtask

    task automatic read_frame(input logic [11:0] exp, input int nb, input string req);
        for (int i = 0; i < nb; i++) begin
            chk(level() == exp[i], req, int'(level()), int'(exp[i]));
            if (i < nb - 1) tick(bit_time());
        end
    endtask

    // From the middle of the last stop bit: tx_end rises exactly at its end.
    task automatic check_end_time(input string req);
        int t;
        t = bit_time();
        tick(t - t / 2 - 1);
        chk(tx_end == 1'b0, req, int'(tx_end), 0);
        tick(1);
        chk(tx_end == 1'b1, req, int'(tx_end), 1);
    endtask

    task automatic send_one(input logic [7:0] d, input string req);
        logic [11:0] f;
        int nb;
        f = model_frame(d, nb);
        write_byte(d);
        find_start(req);
        read_frame(f, nb, req);
        check_end_time(req);
        chk(irq == (tx_end & irq_en[1]) | (buf_empty & irq_en[0]), "R1 irq", int'(irq), 1);
        flag_clr = 2'b10;
        tick(1);
        flag_clr = 2'b00;
        chk(tx_end == 1'b0, "R8 clear end", int'(tx_end), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] fa, fb;
        int na, nb, t, k;
        logic prev;
        bit steady;
        void'($urandom(32'd20250611));

        tick(2);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(tx_out == 1'b1, "R1 idle", int'(tx_out), 1);
        chk(buf_empty == 1'b1, "R1 empty", int'(buf_empty), 1);
        chk(tx_end == 1'b0, "R1 end", int'(tx_end), 0);
        chk(irq == 1'b0, "R1 irq masked", int'(irq), 0);
        irq_en = 2'b01;
        tick(1);
        chk(irq == 1'b1, "R1 irq immediate", int'(irq), 1);

        // R2 not armed: writes ignored
        mod_en = 1'b1;
        write_byte(8'h00);
        steady = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (tx_out != 1'b1) steady = 1'b0;
            tick(1);
        end
        chk(steady, "R2 line idle", int'(steady), 1);
        chk(buf_empty == 1'b1, "R2 still empty", int'(buf_empty), 1);

        sw_rst = 1'b1;
        tick(1);
        sw_rst = 1'b0;
        tick(1);

        // R8 write-1-to-clear of buffer-empty flag
        flag_clr = 2'b01;
        tick(1);
        flag_clr = 2'b00;
        chk(buf_empty == 1'b0, "R8 clear empty", int'(buf_empty), 0);
        chk(irq == 1'b0, "R1 irq follows flag", int'(irq), 0);
        irq_en = 2'b10;

        // Directed corners: R4 7 bits with bit 7 set, R5 odd parity, R6 two stops
        len8 = 1'b0; par_en = 1'b1; par_odd = 1'b1; stop2 = 1'b1; div4 = 1'b1; baud_reload = 8'd0;
        send_one(8'hFF, "R4 R5 R6 short frame");
        len8 = 1'b1; par_en = 1'b1; par_odd = 1'b0; stop2 = 1'b0; div4 = 1'b0; baud_reload = 8'd1;
        send_one(8'hA5, "R5 R7 even parity div16");

        // Random frames: R3 R4 R5 R6 R7
        for (int r = 0; r < 30; r++) begin
            len8 = 1'($urandom); par_en = 1'($urandom); par_odd = 1'($urandom);
            stop2 = 1'($urandom); div4 = 1'($urandom); baud_reload = 8'($urandom % 4);
            send_one(8'($urandom), "R3 R7 random frame");
        end

        // R9 back-to-back, R10 dropped write, R8 flag on load and on write
        len8 = 1'b1; par_en = 1'b1; par_odd = 1'b0; stop2 = 1'b1; div4 = 1'b1; baud_reload = 8'd1;
        t = bit_time();
        fa = model_frame(8'h3C, na);
        fb = model_frame(8'hC1, nb);
        write_byte(8'h3C);
        chk(level() == 1'b1, "R3 idle before start", int'(level()), 1);
        tick(1);
        chk(level() == 1'b0, "R3 start bit", int'(level()), 0);
        chk(buf_empty == 1'b1, "R8 set on load", int'(buf_empty), 1);
        write_byte(8'hC1);
        chk(buf_empty == 1'b0, "R8 write clears", int'(buf_empty), 0);
        write_byte(8'h77);
        tick(t / 2 - 2);
        read_frame(fa, na, "R9 first frame");
        tick(t);
        chk(tx_end == 1'b0, "R9 no end between frames", int'(tx_end), 0);
        read_frame(fb, nb, "R9 second frame no gap");
        check_end_time("R9 end after second");
        steady = 1'b1;
        for (int i = 0; i < 3 * t; i++) begin
            if (level() != 1'b1) steady = 1'b0;
            tick(1);
        end
        chk(steady, "R10 third byte dropped", int'(steady), 1);
        flag_clr = 2'b10;
        tick(1);
        flag_clr = 2'b00;

        // R12 inversion of idle and frame
        inv_out = 1'b1;
        tick(1);
        chk(tx_out == 1'b0, "R12 inverted idle", int'(tx_out), 0);
        send_one(8'h96, "R12 inverted frame");
        inv_out = 1'b0;

        // R13 enable drop mid-frame
        write_byte(8'h00);
        tick(10);
        mod_en = 1'b0;
        tick(1);
        chk(tx_out == 1'b1, "R13 line idle", int'(tx_out), 1);
        chk(buf_empty == 1'b1 && tx_end == 1'b0, "R13 flags reset", int'(buf_empty), 1);
        tick(5);
        mod_en = 1'b1;
        tick(1);
        send_one(8'h5A, "R13 resumes without sw reset");

        // R11 carrier on high periods: half-period check on idle line
        car_period = 8'd5;
        car_low = 1'b0;
        car_en = 1'b1;
        tick(1);
        prev = tx_out;
        k = 0;
        while (tx_out == prev && k < 30) begin tick(1); k++; end
        prev = tx_out;
        k = 0;
        while (tx_out == prev && k < 30) begin tick(1); k++; end
        chk(k == 6, "R11 half period", k, 6);

        // R11 carrier on low periods leaves idle high untouched
        car_low = 1'b1;
        steady = 1'b1;
        for (int i = 0; i < 30; i++) begin
            tick(1);
            if (tx_out != 1'b1) steady = 1'b0;
        end
        chk(steady, "R11 non-target level passes", int'(steady), 1);

        // R12 inversion applied after the carrier stage
        inv_out = 1'b1;
        steady = 1'b1;
        for (int i = 0; i < 30; i++) begin
            tick(1);
            if (tx_out != 1'b0) steady = 1'b0;
        end
        chk(steady, "R12 inversion after carrier", int'(steady), 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule